// File: doc/BRIEF.md
# NAND Flash Device Model

This block is a synthesizable model of a small NAND flash device as seen from its pin side. A host drives a chip-enable, a command-latch and an address-latch line plus an 8- or 16-bit data bus. It pulses a write strobe for each byte or word it sends and a read strobe for each word it takes back. The model decodes command, address and data transfers. It keeps one page-plus-spare buffer, answers identification and status reads, and carries out page read, page program and block erase on an internal array of flops.

The array geometry, the bus width, the page style (small or large) and the device-size class are parameters, scaled down so a simulation can touch every cell. Programming only clears bits: each incoming byte is ANDed into the stored one, and only an erase sets bits back to one. The ready/busy output always reports ready, because every operation finishes in one clock.

Top module: `nand_flash_model`

## Requirements
- R1: After reset every array byte reads 0xFF, `io_out` is 0 and the status value is 0xC0 with `wp_n` high. Status bit 7 is set when writes are allowed, bit 6 is ready (always 1) and bit 0 is the failure flag.
- R2: A write strobe with `ce_n` low is a command when `cle`=1, an address byte when `ale`=1 and `cle`=0, and a data word when both are 0. With `ce_n` high, write strobes are ignored.
- R3: Command 0x90 followed by one address byte makes the next four reads return, in this order, MANF_ID, CHIP_ID, 0xA5 and a geometry byte. The geometry byte is 0x15 for a large-page part on an 8-bit bus, 0x55 for a large-page part on a 16-bit bus, and 0xC0 for a small-page part. On a 16-bit bus each of these bytes sits in bits 7:0 and bits 15:8 are zero.
- R4: Address bytes arrive little-endian: first the column bytes (1 on small-page parts, 2 on large-page parts), then the row bytes, which give the page index. A read (0x00) or a program (0x80) starts only when the last address byte arrives. That is the 3rd byte on small-page parts, the 4th on large-page parts with BIG_ARRAY=0, and the 5th on large-page parts with BIG_ARRAY=1.
- R5: The column is given in bus words. When the second address byte arrives, the column is multiplied by the bus width in bytes, so a word column of 3 on a 16-bit bus starts at byte 6.
- R6: Program confirm (0x10) ANDs each buffered byte into the addressed cells, so bits only go from 1 to 0. If `wp_n` is low when program or erase is confirmed, the array is left unchanged and status bit 0 is set.
- R7: After command 0x70, every read returns the status value in bits 7:0 and does not move the read pointer, until the next recognised command.
- R8: Erase setup (0x60), row bytes only, then confirm (0xD0) sets every byte of the block holding that page, spare bytes included, to 0xFF. A block is PAGES_PER_BLK consecutive pages.
- R9: Program data is taken into the buffer only until it holds PAGE_BYTES+OOB_BYTES bytes; later words are dropped. A 16-bit word is stored low byte first.
- R10: Each read returns the buffer bytes at the pointer (lowest byte in the lowest bits) and advances by the bus width. Once the page-plus-spare end is passed, a read returns 0. A read with `ce_n` high returns 0.
- R11: A read or program that addresses a page index at or beyond NUM_PAGES does not touch the array, and reads after it return 0.
- R12: Command 0xFF returns the model to read mode, clears the address and the failure bit, and keeps the write-protect bit. Command bytes other than 0x00, 0x10, 0x60, 0x70, 0x80, 0x90, 0xD0 and 0xFF change nothing.
- R13: `rb_n` is always 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| cle | input | 1 | Command latch enable |
| ale | input | 1 | Address latch enable |
| wp_n | input | 1 | Write protect, active low |
| we_stb | input | 1 | One-cycle write strobe for a command, address or data transfer |
| re_stb | input | 1 | One-cycle read strobe |
| io_in | input | BUS_W | Data bus into the device (commands and addresses in bits 7:0) |
| io_out | output | BUS_W | Registered read data, updated on each read strobe |
| rb_n | output | 1 | Ready/busy, active low busy |

## Verification
The bench counts address cycles on the 5-cycle configuration, so a model that starts reading one cycle early returns page data where zero is expected. It reads back with a nonzero word column; a missing or doubled column scaling shifts every word it compares. Pages are programmed over and over without erase: a model that overwrote instead of ANDing would bring back bits that should stay cleared. Status reads are repeated, mixed with an unrecognised command and with `ce_n` toggled, and the run also covers protected program and erase, out-of-range pages and reads past the spare area. Faults there show up as a moving status value, a cleared failure bit or nonzero words after the buffer end.

// File: rtl/nandm_pkg.sv
// Shared command codes and status bit positions for the NAND flash model.
// Assumes commands and addresses always travel on bits 7:0 of the bus.
package nandm_pkg;

    typedef enum logic [7:0] {
        OP_READ          = 8'h00,
        OP_PROG_CONFIRM  = 8'h10,
        OP_ERASE_SETUP   = 8'h60,
        OP_STATUS        = 8'h70,
        OP_PROG_SETUP    = 8'h80,
        OP_READ_ID       = 8'h90,
        OP_ERASE_CONFIRM = 8'hD0,
        OP_RESET         = 8'hFF
    } nand_op_e;

    localparam int ST_UNPROT = 7;
    localparam int ST_READY  = 6;
    localparam int ST_FAIL   = 0;

    localparam logic [7:0] ID_FILLER = 8'hA5;

    // True for the command bytes the model acts on.
    function automatic logic op_known(input logic [7:0] b);
        case (b)
            OP_READ, OP_PROG_CONFIRM, OP_ERASE_SETUP, OP_STATUS,
            OP_PROG_SETUP, OP_READ_ID, OP_ERASE_CONFIRM, OP_RESET: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/nandm_addr_seq.sv
// Address cycle collector: gathers little-endian column and row bytes and
// counts the cycles. It scales the column to bytes on the second cycle.
// Assumes a command write clears it before each new address phase.
module nandm_addr_seq #(
    parameter int COL_CYC   = 2,
    parameter int BUS_BYTES = 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        strobe,
    input  logic        row_only,
    input  logic [7:0]  data,
    output logic [15:0] col,
    output logic [23:0] row,
    output logic [2:0]  cnt
);
    localparam int SHIFT = BUS_BYTES - 1;

    logic [15:0] col_n;
    logic [23:0] row_n;
    logic [2:0]  ridx;

    // Next column and row values for the incoming address byte.
    always_comb begin
        ridx  = row_only ? cnt : cnt - 3'(COL_CYC);
        col_n = col;
        row_n = row;
        if (!row_only && cnt < 3'(COL_CYC)) begin
            col_n = col | ({8'h00, data} << {cnt, 3'b000});
        end else if (ridx < 3'd3) begin
            row_n = row | ({16'h0000, data} << {ridx, 3'b000});
        end
        if (!row_only && cnt == 3'd1) begin
            col_n = col_n << SHIFT;
        end
    end

    // Address registers and cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            col <= '0;
            row <= '0;
            cnt <= '0;
        end else if (strobe && cnt != 3'd7) begin
            col <= col_n;
            row <= row_n;
            cnt <= cnt + 3'd1;
        end
    end

    // R4: every accepted address byte adds exactly one to the cycle count.
    a_r4_cycle_step: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !clr && cnt != 3'd7) |=> (cnt == $past(cnt) + 3'd1));

endmodule

// File: rtl/nandm_iobuf.sv
// Page-plus-spare I/O buffer. It is loaded from the array or with the ID
// bytes, filled by program data words and drained by read strobes. Only
// one operation input is expected to be active per cycle.
module nandm_iobuf #(
    parameter int BUF_N     = 20,
    parameter int BUS_BYTES = 1,
    parameter int LEN_W     = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clear,
    input  logic                   load_en,
    input  logic [BUF_N*8-1:0]     load_data,
    input  logic [15:0]            load_col,
    input  logic                   id_en,
    input  logic [31:0]            id_bytes,
    input  logic                   push_en,
    input  logic [BUS_BYTES*8-1:0] push_word,
    input  logic                   pop_en,
    output logic [BUS_BYTES*8-1:0] word_out,
    output logic [LEN_W-1:0]       len,
    output logic [BUF_N*8-1:0]     buf_flat
);
    localparam int IDX_W = $clog2(BUF_N);

    logic [7:0]  mem [BUF_N];
    logic [15:0] ptr;

    // Buffer contents, read pointer and valid length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
            len <= '0;
            for (int b = 0; b < BUF_N; b++) mem[b] <= 8'h00;
        end else if (clear) begin
            ptr <= '0;
            len <= '0;
        end else if (load_en) begin
            for (int b = 0; b < BUF_N; b++) mem[b] <= load_data[b*8 +: 8];
            ptr <= load_col;
            len <= (int'(load_col) < BUF_N) ? LEN_W'(BUF_N - int'(load_col)) : '0;
        end else if (id_en) begin
            for (int b = 0; b < BUF_N; b++) mem[b] <= 8'h00;
            for (int i = 0; i < 4; i++) mem[IDX_W'(i*BUS_BYTES)] <= id_bytes[i*8 +: 8];
            ptr <= '0;
            len <= LEN_W'(4*BUS_BYTES);
        end else if (push_en && int'(len) < BUF_N) begin
            for (int i = 0; i < BUS_BYTES; i++) begin
                if (int'(len) + i < BUF_N) mem[IDX_W'(int'(len) + i)] <= push_word[i*8 +: 8];
            end
            len <= len + LEN_W'(BUS_BYTES);
        end else if (pop_en && len != '0) begin
            ptr <= ptr + 16'(BUS_BYTES);
            len <= (int'(len) > BUS_BYTES) ? len - LEN_W'(BUS_BYTES) : '0;
        end
    end

    // Word at the read pointer, zero where no valid byte remains.
    always_comb begin
        for (int i = 0; i < BUS_BYTES; i++) begin
            if (int'(len) > i && int'(ptr) + i < BUF_N)
                word_out[i*8 +: 8] = mem[IDX_W'(int'(ptr) + i)];
            else
                word_out[i*8 +: 8] = 8'h00;
        end
    end

    for (genvar g = 0; g < BUF_N; g++) begin : g_flat
        assign buf_flat[g*8 +: 8] = mem[g];
    end

    // R9: the valid length never exceeds one page plus spare.
    a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        int'(len) <= BUF_N);

    // R10: a lone read pop moves pointer and length by one bus width.
    a_r10_pop_step: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_en && !clear && !load_en && !id_en && !push_en && int'(len) >= BUS_BYTES)
        |=> (len == $past(len) - LEN_W'(BUS_BYTES)) && (ptr == $past(ptr) + 16'(BUS_BYTES)));

endmodule

// File: rtl/nandm_array.sv
// Flop-based cell array of PAGES pages of BUF_N bytes. It resets to all
// ones, programs by AND over a column window and erases whole blocks.
// Assumes callers only enable program or erase with a valid page index.
module nandm_array #(
    parameter int PAGES = 16,
    parameter int BUF_N = 20,
    parameter int PPB   = 4,
    parameter int PG_W  = 4,
    parameter int LEN_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PG_W-1:0]    rd_page,
    output logic [BUF_N*8-1:0] rd_data,
    input  logic               prog_en,
    input  logic [PG_W-1:0]    prog_page,
    input  logic [15:0]        prog_col,
    input  logic [LEN_W-1:0]   prog_len,
    input  logic [BUF_N*8-1:0] prog_data,
    input  logic               erase_en,
    input  logic [PG_W-1:0]    erase_page
);
    logic [7:0] mem [PAGES][BUF_N];

    // Cell updates: reset fill, AND programming, block erase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < PAGES; p++)
                for (int b = 0; b < BUF_N; b++) mem[p][b] <= 8'hFF;
        end else begin
            if (prog_en) begin
                for (int b = 0; b < BUF_N; b++) begin
                    if (b >= int'(prog_col) && (b - int'(prog_col)) < int'(prog_len))
                        mem[prog_page][b] <= mem[prog_page][b]
                                           & prog_data[(b - int'(prog_col))*8 +: 8];
                end
            end
            if (erase_en) begin
                for (int p = 0; p < PAGES; p++) begin
                    if (p / PPB == int'(erase_page) / PPB)
                        for (int b = 0; b < BUF_N; b++) mem[p][b] <= 8'hFF;
                end
            end
        end
    end

    for (genvar g = 0; g < BUF_N; g++) begin : g_rd
        assign rd_data[g*8 +: 8] = mem[rd_page][g];
    end

    // R6: programming a page never sets a bit that was clear.
    a_r6_and_only: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_en && !erase_en && rd_page == prog_page)
        |=> (rd_page != $past(rd_page)) || ((rd_data & ~$past(rd_data)) == '0));

    // R8: after an erase of the block being viewed, every byte reads 0xFF.
    a_r8_block_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_en && int'(rd_page) / PPB == int'(erase_page) / PPB)
        |=> (rd_page != $past(rd_page)) || (&rd_data));

endmodule

// File: rtl/nand_flash_model.sv
// NAND flash device model top. Decodes command, address and data strobes,
// sequences read, ID, status, program and erase, and drives the read bus.
// Assumes one strobe per cycle; every operation completes in one clock.
module nand_flash_model
    import nandm_pkg::*;
#(
    parameter int         BUS_W         = 8,
    parameter int         PAGE_BYTES    = 16,
    parameter int         OOB_BYTES     = 4,
    parameter int         PAGES_PER_BLK = 4,
    parameter int         NUM_PAGES     = 16,
    parameter bit         LARGE_PAGE    = 1'b1,
    parameter bit         BIG_ARRAY     = 1'b0,
    parameter logic [7:0] MANF_ID       = 8'hEC,
    parameter logic [7:0] CHIP_ID       = 8'hF1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce_n,
    input  logic             cle,
    input  logic             ale,
    input  logic             wp_n,
    input  logic             we_stb,
    input  logic             re_stb,
    input  logic [BUS_W-1:0] io_in,
    output logic [BUS_W-1:0] io_out,
    output logic             rb_n
);
    localparam int BB       = BUS_W / 8;
    localparam int BUF_N    = PAGE_BYTES + OOB_BYTES;
    localparam int COL_CYC  = LARGE_PAGE ? 2 : 1;
    localparam int ADDR_CYC = LARGE_PAGE ? (BIG_ARRAY ? 5 : 4) : 3;
    localparam int ROW_CYC  = ADDR_CYC - COL_CYC;
    localparam int PG_W     = $clog2(NUM_PAGES);
    localparam int LEN_W    = $clog2(BUF_N + 1) + 1;
    localparam logic [7:0] GEOM_ID = LARGE_PAGE ? ((BB == 2) ? 8'h55 : 8'h15) : 8'hC0;

    logic [7:0]  op, cmd_q, status;
    logic        unprot_q, fail_q, start_q;
    logic        is_cmd, is_addr, is_data;
    logic [15:0] col;
    logic [23:0] row;
    logic [2:0]  cnt, tgt;
    logic        addr_clr, page_ok, addr_done, erase_ready;
    logic        prog_go, erase_go, prot_hit, buf_clear;
    logic        load_en, id_en, push_en, pop_en;
    logic [BUF_N*8-1:0] arr_rd, buf_flat;
    logic [BUS_W-1:0]   word_out, stat_word;
    logic [LEN_W-1:0]   buf_len;

    // Transfer decode and operation enables.
    always_comb begin
        op          = io_in[7:0];
        is_cmd      = we_stb && !ce_n && cle;
        is_addr     = we_stb && !ce_n && ale && !cle;
        is_data     = we_stb && !ce_n && !cle && !ale;
        addr_clr    = is_cmd && (op == OP_READ || op == OP_READ_ID || op == OP_PROG_SETUP
                                 || op == OP_ERASE_SETUP || op == OP_RESET);
        tgt         = (cmd_q == OP_READ_ID) ? 3'd1 :
                      (cmd_q == OP_READ || cmd_q == OP_PROG_SETUP) ? 3'(ADDR_CYC) : 3'd0;
        page_ok     = row < 24'(NUM_PAGES);
        addr_done   = (cmd_q == OP_PROG_SETUP) && int'(cnt) >= ADDR_CYC;
        erase_ready = (cmd_q == OP_ERASE_SETUP) && int'(cnt) >= ROW_CYC;
        prog_go     = is_cmd && op == OP_PROG_CONFIRM && addr_done && unprot_q && page_ok;
        erase_go    = is_cmd && op == OP_ERASE_CONFIRM && erase_ready && unprot_q && page_ok;
        prot_hit    = is_cmd && !unprot_q
                      && ((op == OP_PROG_CONFIRM && cmd_q == OP_PROG_SETUP)
                          || (op == OP_ERASE_CONFIRM && cmd_q == OP_ERASE_SETUP));
        buf_clear   = addr_clr || (is_cmd && (op == OP_PROG_CONFIRM || op == OP_ERASE_CONFIRM));
        load_en     = start_q && cmd_q == OP_READ && page_ok;
        id_en       = start_q && cmd_q == OP_READ_ID;
        push_en     = is_data && addr_done;
        pop_en      = re_stb && !ce_n && cmd_q != OP_STATUS;
        status      = {unprot_q, 1'b1, 5'b00000, fail_q};
        stat_word   = '0;
        stat_word[7:0] = status;
    end

    // Current command register; unknown bytes leave it alone.
    always_ff @(posedge clk) begin
        if (!rst_n)                      cmd_q <= OP_READ;
        else if (is_cmd && op_known(op)) cmd_q <= (op == OP_RESET) ? OP_READ : op;
    end

    // Status flags: write-protect sample and failure flag.
    always_ff @(posedge clk) begin
        unprot_q <= wp_n;
        if (!rst_n || (is_cmd && op == OP_RESET)) fail_q <= 1'b0;
        else if (prot_hit)                        fail_q <= 1'b1;
    end

    // One-cycle start pulse when the last needed address byte is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) start_q <= 1'b0;
        else        start_q <= is_addr && cnt != 3'd7 && tgt != 3'd0 && (cnt + 3'd1) == tgt;
    end

    // Registered read bus.
    always_ff @(posedge clk) begin
        if (!rst_n)                 io_out <= '0;
        else if (re_stb) begin
            if (ce_n)                    io_out <= '0;
            else if (cmd_q == OP_STATUS) io_out <= stat_word;
            else                         io_out <= word_out;
        end
    end

    assign rb_n = 1'b1;

    nandm_addr_seq #(.COL_CYC(COL_CYC), .BUS_BYTES(BB)) u_addr (
        .clk(clk), .rst_n(rst_n), .clr(addr_clr), .strobe(is_addr),
        .row_only(cmd_q == OP_ERASE_SETUP), .data(op),
        .col(col), .row(row), .cnt(cnt)
    );

    nandm_iobuf #(.BUF_N(BUF_N), .BUS_BYTES(BB), .LEN_W(LEN_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .clear(buf_clear),
        .load_en(load_en), .load_data(arr_rd), .load_col(col),
        .id_en(id_en), .id_bytes({GEOM_ID, ID_FILLER, CHIP_ID, MANF_ID}),
        .push_en(push_en), .push_word(io_in), .pop_en(pop_en),
        .word_out(word_out), .len(buf_len), .buf_flat(buf_flat)
    );

    nandm_array #(.PAGES(NUM_PAGES), .BUF_N(BUF_N), .PPB(PAGES_PER_BLK),
                  .PG_W(PG_W), .LEN_W(LEN_W)) u_arr (
        .clk(clk), .rst_n(rst_n), .rd_page(row[PG_W-1:0]), .rd_data(arr_rd),
        .prog_en(prog_go), .prog_page(row[PG_W-1:0]), .prog_col(col),
        .prog_len(buf_len), .prog_data(buf_flat),
        .erase_en(erase_go), .erase_page(row[PG_W-1:0])
    );

    // R12: the reset command lands in read mode with a fresh address and no failure.
    a_r12_reset_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (is_cmd && op == OP_RESET) |=> (cmd_q == OP_READ && cnt == 3'd0 && !fail_q));

    // R10: a read strobe with chip enable high yields zero.
    a_r10_ce_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (re_stb && ce_n) |=> (io_out == '0));

    // R6: a confirm while write-protected raises the failure flag.
    a_r6_prot_fail: assert property (@(posedge clk) disable iff (!rst_n)
        (is_cmd && !wp_n && $past(!wp_n) && op == OP_PROG_CONFIRM && cmd_q == OP_PROG_SETUP)
        |=> fail_q);

    // R7: status reads leave the buffer length untouched.
    a_r7_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (re_stb && !ce_n && !we_stb && cmd_q == OP_STATUS) |=> $stable(buf_len));

endmodule

// File: tb/nand_flash_model_tb_top.sv
// Self-checking bench: 16-bit bus, large pages, five address cycles.
module nand_flash_model_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NP  = 16;
    localparam int BN  = 20;
    localparam int PPB = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ce_n = 1'b0, cle = 1'b0, ale = 1'b0, wp_n = 1'b1, we_stb = 1'b0, re_stb = 1'b0;
    logic [15:0] io_in = '0;
    logic [15:0] io_out;
    logic rb_n;

    int n_chk = 0, n_err = 0;
    bit finished = 1'b0;
    logic [7:0] mdl [NP][BN];

    always #(CLK_PERIOD/2) clk = ~clk;

    nand_flash_model #(.BUS_W(16), .PAGE_BYTES(16), .OOB_BYTES(4), .PAGES_PER_BLK(PPB),
                       .NUM_PAGES(NP), .LARGE_PAGE(1'b1), .BIG_ARRAY(1'b1),
                       .MANF_ID(8'hEC), .CHIP_ID(8'hDA)) dut_i (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale), .wp_n(wp_n),
        .we_stb(we_stb), .re_stb(re_stb), .io_in(io_in), .io_out(io_out), .rb_n(rb_n)
    );

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic c, input logic a, input logic [15:0] v);
        @(negedge clk); cle = c; ale = a; io_in = v; we_stb = 1'b1;
        @(negedge clk); we_stb = 1'b0; cle = 1'b0; ale = 1'b0;
        @(negedge clk);
    endtask

    task automatic cmd(input logic [7:0] b); wr(1'b1, 1'b0, {8'h00, b}); endtask
    task automatic adr(input logic [7:0] b); wr(1'b0, 1'b1, {8'h00, b}); endtask

    task automatic rd(output logic [15:0] w);
        @(negedge clk); re_stb = 1'b1;
        @(negedge clk); re_stb = 1'b0; w = io_out;
    endtask

    task automatic addr5(input int colw, input int pg);
        adr(8'(colw)); adr(8'(colw >> 8)); adr(8'(pg)); adr(8'(pg >> 8)); adr(8'(pg >> 16));
    endtask

    function automatic logic [15:0] exp_word(input int pg, input int bi);
        if (pg >= NP || bi >= BN) return 16'h0000;
        return {mdl[pg][bi+1], mdl[pg][bi]};
    endfunction

    // Read a page from a word column to one word past the end (R5, R10, R11).
    task automatic read_cmp(input int pg, input int colw, input string req);
        logic [15:0] w;
        cmd(8'h00); addr5(colw, pg);
        for (int k = colw; k <= BN/2; k++) begin
            rd(w); chk(w, exp_word(pg, 2*k), req);
        end
    endtask

    // Program n random words at a word column; model applies R6 AND and R9 capacity.
    task automatic do_prog(input int pg, input int colw, input int n, input bit upd);
        logic [7:0] bb [BN];
        int len = 0;
        logic [15:0] w;
        cmd(8'h80); addr5(colw, pg);
        for (int k = 0; k < n; k++) begin
            w = 16'($urandom) | 16'($urandom);
            wr(1'b0, 1'b0, w);
            if (len < BN) begin bb[len] = w[7:0]; bb[len+1] = w[15:8]; len += 2; end
        end
        cmd(8'h10);
        if (upd && pg < NP)
            for (int j = 0; j < len; j++)
                if (colw*2 + j < BN) mdl[pg][colw*2 + j] &= bb[j];
    endtask

    task automatic do_erase(input int pg, input bit upd);
        cmd(8'h60); adr(8'(pg)); adr(8'h00); adr(8'h00); cmd(8'hD0);
        if (upd && pg < NP)
            for (int p = 0; p < NP; p++)
                if (p / PPB == pg / PPB) for (int b = 0; b < BN; b++) mdl[p][b] = 8'hFF;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] w;
        void'($urandom(32'h5EED1234));
        for (int p = 0; p < NP; p++) for (int b = 0; b < BN; b++) mdl[p][b] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1, R13: reset state
        chk(io_out, 16'h0000, "R1 io_out after reset");
        chk({15'h0, rb_n}, 16'h0001, "R13 ready");
        cmd(8'h70); rd(w); chk(w, 16'h00C0, "R1 status after reset");
        read_cmp(0, 0, "R1 erased page");

        // R3: ID words, then buffer end
        cmd(8'h90); adr(8'h00);
        rd(w); chk(w, 16'h00EC, "R3 manufacturer");
        rd(w); chk(w, 16'h00DA, "R3 chip");
        rd(w); chk(w, 16'h00A5, "R3 filler");
        rd(w); chk(w, 16'h0055, "R3 geometry x16");
        rd(w); chk(w, 16'h0000, "R10 past ID");

        // R4: four address bytes do not start the read, the fifth does
        do_prog(7, 0, 10, 1'b1);
        cmd(8'h00); adr(8'h00); adr(8'h00); adr(8'h07); adr(8'h00);
        rd(w); chk(w, 16'h0000, "R4 not started after 4 cycles");
        adr(8'h00);
        rd(w); chk(w, exp_word(7, 0), "R4 started after 5 cycles");

        // R5: word column 3 starts at byte 6
        read_cmp(7, 3, "R5 column scaling");

        // R6: repeated program without erase only clears bits
        do_prog(9, 2, 6, 1'b1);
        do_prog(9, 0, 10, 1'b1);
        read_cmp(9, 0, "R6 AND program");

        // R9: more words than the buffer holds
        do_prog(10, 4, 14, 1'b1);
        read_cmp(10, 0, "R9 capacity");

        // R8: erase restores a block, spare included
        do_erase(9, 1'b1);
        read_cmp(8, 0, "R8 erase block");
        read_cmp(10, 0, "R8 erase block");

        // R11: out-of-range page
        read_cmp(20, 0, "R11 read beyond array");
        do_prog(20, 0, 10, 1'b0);
        read_cmp(4, 0, "R11 program beyond array");

        // R7, R2, R12: status stickiness, ignored strobes, unknown command
        cmd(8'h70);
        rd(w); chk(w, 16'h00C0, "R7 status read 1");
        rd(w); chk(w, 16'h00C0, "R7 status read 2");
        ce_n = 1'b1;
        cmd(8'h90);
        rd(w); chk(w, 16'h0000, "R10 ce_n high read");
        ce_n = 1'b0;
        rd(w); chk(w, 16'h00C0, "R2 command ignored with ce_n high");
        cmd(8'h30);
        rd(w); chk(w, 16'h00C0, "R12 unknown command ignored");

        // R6: write protect blocks program and erase, sets failure bit
        do_prog(12, 0, 8, 1'b1);
        wp_n = 1'b0;
        @(negedge clk);
        do_prog(12, 0, 10, 1'b0);
        do_erase(12, 1'b0);
        cmd(8'h70); rd(w); chk(w, 16'h0041, "R6 protected status");
        read_cmp(12, 0, "R6 protected array unchanged");
        wp_n = 1'b1;
        @(negedge clk);
        cmd(8'hFF); cmd(8'h70); rd(w); chk(w, 16'h00C0, "R12 reset command status");
        cmd(8'hFF);
        rd(w); chk(w, 16'h0000, "R12 reset command empties buffer");

        // Random mix of program, erase and read
        for (int it = 0; it < 40; it++) begin
            int pg, sel;
            pg  = int'($urandom_range(0, NP-1));
            sel = int'($urandom_range(0, 3));
            if (sel == 0)      do_erase(pg, 1'b1);
            else if (sel == 1) do_prog(pg, int'($urandom_range(0, 9)), int'($urandom_range(1, 12)), 1'b1);
            else               read_cmp(pg, int'($urandom_range(0, 9)), "R10 random read");
        end
        for (int p = 0; p < NP; p++) read_cmp(p, 0, "R6 final sweep");
        chk({15'h0, rb_n}, 16'h0001, "R13 ready at end");

        finish_run();
    end
endmodule